// File: doc/BRIEF.md
# Delayed Steering Guard-Time Validator

This block sits behind a dual-tone detector. It turns the detector's raw early-steering level into a delayed steering output that marks a validated digit. The output rises only after the early-steering level has stayed high for a full tone-present guard interval. Once it is high, it falls only after the early-steering level has stayed low for a full tone-absent guard interval. Short bursts are therefore never reported, and short dropouts inside a digit do not split it in two.

Both guard intervals are counted in ticks of an internal enable. A prescaler derives this enable from the clock. With `TICK_DIV` = 1 the enable is high on every cycle. A single counter serves both guard phases, and a two-state machine (idle, validated) selects which guard is being timed. The power-down input forces the output low at once and clears all timing state.

Top module: `dsteer_guard`

## Requirements
- R1: While `rst_ni` is low, `dsteer_o` is 0, and after reset the block is idle with its guard count cleared.
- R2: From idle, `dsteer_o` becomes 1 at the end of the tick on which `est_i` has been sampled high on `PRESENT_TICKS` consecutive ticks.
- R3: A burst of `est_i` that lasts fewer than `PRESENT_TICKS` ticks never drives `dsteer_o` high.
- R4: A low sample of `est_i` during the present guard restarts it, so a full `PRESENT_TICKS` run of high samples is needed again.
- R5: While validated, a low run of `est_i` shorter than `ABSENT_TICKS` ticks leaves `dsteer_o` at 1.
- R6: While validated, `dsteer_o` becomes 0 at the end of the tick on which `est_i` has been sampled low on `ABSENT_TICKS` consecutive ticks.
- R7: A high sample of `est_i` during the absent guard restarts it, so a full `ABSENT_TICKS` run of low samples is needed again.
- R8: While `pwdn_i` is 1, `dsteer_o` is 0 in the same cycle, whatever the value of `est_i`.
- R9: Power-down returns the block to idle with its count cleared, so after `pwdn_i` falls a full present guard is needed before `dsteer_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| est_i | input | 1 | Raw early-steering level from the tone detector |
| pwdn_i | input | 1 | Power-down; high forces the output low and clears the guard state |
| dsteer_o | output | 1 | Validated (delayed) steering output |

## Verification
The assertions assume that `est_i` and `pwdn_i` are synchronous to `clk_i` and settle away from the rising edge. A rise of the output must then trace back to a high sample of `est_i`, and a fall (outside power-down) to a low sample. The stimulus changes inputs only on falling edges and holds each level for whole cycles. The bench runs with one tick per clock, so every guard boundary falls on a known edge. The runs are chosen to land exactly one tick short of each guard and exactly on it.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_VALID = 1'b1
  } dsteer_state_e;
endpackage

// File: rtl/dsteer_tick.sv
module dsteer_tick #(
  parameter int TICK_DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every_cycle
      assign tick_o = 1'b1;
    end else begin : g_prescale
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] DLAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               div_q <= '0;
        else if (clr_i || tick_o)  div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
      assign tick_o = (div_q == DLAST);
    end
  endgenerate
endmodule

// File: rtl/dsteer_cnt.sv
module dsteer_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = inc_i && (cnt_q == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else if (inc_i)          cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_i || $past(last_i) != last_i || cnt_q == '0);
endmodule

// File: rtl/dsteer_guard.sv
module dsteer_guard
  import dsteer_pkg::*;
#(
  parameter int TICK_DIV      = 50000,
  parameter int PRESENT_TICKS = 40,
  parameter int ABSENT_TICKS  = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic est_i,
  input  logic pwdn_i,
  output logic dsteer_o
);
  localparam int GUARD_MAX = (PRESENT_TICKS > ABSENT_TICKS) ? PRESENT_TICKS : ABSENT_TICKS;
  localparam int CNT_W     = $clog2(GUARD_MAX + 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PRESENT_TICKS - 1);
  localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ABSENT_TICKS - 1);

  dsteer_state_e state_q;
  logic tick, run, done;
  logic [CNT_W-1:0] last;

  dsteer_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pwdn_i),
    .tick_o (tick)
  );

  // idle times high samples, validated times low samples
  assign run  = (state_q == ST_IDLE) ? est_i : !est_i;
  assign last = (state_q == ST_IDLE) ? P_LAST : A_LAST;

  dsteer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (pwdn_i || !run),
    .inc_i  (run && tick && !pwdn_i),
    .last_i (last),
    .done_o (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= ST_IDLE;
    else if (pwdn_i) state_q <= ST_IDLE;
    else if (done)   state_q <= (state_q == ST_IDLE) ? ST_VALID : ST_IDLE;
  end

  assign dsteer_o = (state_q == ST_VALID) && !pwdn_i;

  // R8
  pwdn_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwdn_i |-> !dsteer_o);
  // R2
  rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dsteer_o) |-> $past(est_i));
  // R6
  fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dsteer_o) && !pwdn_i) |-> !$past(est_i));
  // R3
  no_rise_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dsteer_o && !est_i) |=> !dsteer_o);
  // R5
  hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsteer_o && est_i && !pwdn_i) |=> (dsteer_o || pwdn_i));
endmodule

// File: tb/dsteer_guard_test.sv
module dsteer_guard_test;
  localparam int P = 8;
  localparam int A = 5;

  logic clk = 1'b0, rst_n = 1'b0, est = 1'b0, pwdn = 1'b0;
  logic dsteer;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  logic  exp_q[$];
  string tag_q[$];
  bit m_valid = 0;
  int m_run = 0;

  always #10 clk = ~clk;

  dsteer_guard #(.TICK_DIV(1), .PRESENT_TICKS(P), .ABSENT_TICKS(A)) uut (
    .clk_i(clk), .rst_ni(rst_n), .est_i(est), .pwdn_i(pwdn), .dsteer_o(dsteer)
  );

  task automatic step(input logic e, input logic pd, input string tag);
    @(negedge clk);
    est = e; pwdn = pd;
    if (pd) begin m_valid = 0; m_run = 0; end
    else if (!m_valid) begin
      if (e) begin m_run++; if (m_run == P) begin m_valid = 1; m_run = 0; end end
      else m_run = 0;
    end else begin
      if (!e) begin m_run++; if (m_run == A) begin m_valid = 0; m_run = 0; end end
      else m_run = 0;
    end
    exp_q.push_back(m_valid && !pd);
    tag_q.push_back(tag);
  endtask

  task automatic run(input logic e, input logic pd, input int n, input string tag);
    for (int i = 0; i < n; i++) step(e, pd, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic  x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (dsteer !== x) begin
          n_bad++;
          $display("FAIL %s: dsteer_o=%b expected %b at %0t", t, dsteer, x, $time);
        end
      end
    end
  end

  initial begin
    est = 1'b1;
    repeat (3) @(negedge clk);
    n_vec++;
    if (dsteer !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: dsteer_o=%b expected 0 in reset", dsteer);
    end
    est = 1'b0;
    rst_n = 1'b1;
    run(0, 0, 3, "R1");
    run(1, 0, P - 1, "R3");
    run(0, 0, 3, "R3");
    run(1, 0, 5, "R4");
    run(0, 0, 1, "R4");
    run(1, 0, P - 1, "R4");
    run(1, 0, 1, "R2");
    run(1, 0, 2, "R2");
    run(0, 0, A - 1, "R5");
    run(1, 0, 2, "R5");
    run(0, 0, A - 1, "R7");
    run(1, 0, 1, "R7");
    run(0, 0, A - 1, "R7");
    run(0, 0, 1, "R6");
    run(0, 0, 2, "R6");
    run(1, 0, P, "R2");
    run(1, 1, 3, "R8");
    run(1, 0, P - 1, "R9");
    run(1, 0, 2, "R9");
    run(0, 1, 1, "R8");
    run(0, 0, 2, "R8");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule